// File: doc/BRIEF.md
# Instruction Cycle and Interrupt Sequencer

This block sequences the instruction cycle of a small 16-bit accumulator machine. A 4-bit step counter drives sixteen one-hot timing lines. The block fetches the instruction word from a 4096 x 16 memory, decodes its 3-bit opcode into eight one-hot lines, and captures the address field and the indirect bit. It resolves one level of indirection at step 3. The instructions themselves are executed by separate units. Those units watch the timing and opcode lines, and they send back three requests: a counter restart, a program-counter increment and a program-counter load.

Interrupt entry is part of the block. While interrupts are enabled and a device flag is raised during execution, a pending flag is set. At the next return to step 0, the block does not fetch. It runs a three-step entry cycle instead: the return address is stored in word 0, control passes to word 1, and interrupts are disabled. A run input, driven by the machine's start/stop flip-flop, freezes every register while it is low.

The phase is a pure function of the step counter, the pending flag, the opcode and the indirect bit. The phases and their transitions are:

- FETCH_ADDR (step 0, no interrupt pending) goes to FETCH_READ.
- FETCH_READ (step 1) goes to DECODE.
- DECODE (step 2) goes to INDIRECT when the opcode is below 7 and the indirect bit is set; otherwise it goes to EXECUTE.
- INDIRECT (step 3) goes to EXECUTE.
- EXECUTE (any step from 3 up) stays in EXECUTE. It goes back to step 0 on a restart request or when the counter wraps from 15.
- From step 0 with the pending flag set, the block runs INT_SAVE, then INT_STORE, then INT_VECTOR, and then returns to step 0.

Top module: `instr_cycle_seq`

## Requirements
- R1: After reset, the step counter is 0, only timing line 0 is high, and the pending flag and interrupt enable are 0. PC, AR, IR, TR and the indirect bit are also 0.
- R2: On every clock with run high, the step counter advances by one and wraps from 15 to 0. Timing line k is high exactly when the counter equals k. A restart request returns the counter to 0 on the next edge, but only in EXECUTE.
- R3: FETCH_ADDR copies PC into AR. The memory read is combinational at address AR. FETCH_READ loads IR with the word read and increments PC modulo 4096.
- R4: Opcode line k is high exactly when IR bits 14..12 equal k. DECODE loads AR from IR bits 11..0 and the indirect bit from IR bit 15.
- R5: INDIRECT (step 3, opcode below 7, indirect bit 1, no interrupt pending) loads AR from bits 11..0 of the word read. At step 3 with opcode 7 or with the indirect bit 0, AR is left unchanged.
- R6: The pending flag is set after any clock with run high in which the counter is 3 or more, the flag is clear, the interrupt enable is 1, and at least one of the two device flags is 1.
- R7: INT_SAVE clears AR and loads TR with PC. INT_STORE writes TR to memory at AR and clears PC; the write strobe is high in no other phase. INT_VECTOR makes PC 1, clears the interrupt enable and the pending flag, and returns the counter to 0.
- R8: In EXECUTE, a load request sets PC to the supplied address; otherwise an increment request adds one to PC. In every other phase both requests have no effect on PC.
- R9: The interrupt-off request clears the enable and the interrupt-on request sets it; off wins when both are present. In INT_VECTOR the enable is cleared whatever the requests.
- R10: While run is low, the counter and all registers hold their values and the write strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start/stop state; low freezes the block |
| in_flag | input | 1 | Input device ready flag |
| out_flag | input | 1 | Output device ready flag |
| sc_clear | input | 1 | Restart request from an execute unit |
| pc_inc_req | input | 1 | PC increment request (skip) |
| pc_load_req | input | 1 | PC load request (branch) |
| pc_load_addr | input | 12 | Branch target for a load request |
| ien_on | input | 1 | Interrupt enable set request |
| ien_off | input | 1 | Interrupt enable clear request |
| mem_rdata | input | 16 | Memory read data at mem_addr |
| mem_addr | output | 12 | Memory address (AR) |
| mem_wdata | output | 16 | Memory write data (TR) |
| mem_we | output | 1 | Memory write strobe |
| op_lines | output | 8 | One-hot decoded opcode |
| tstep | output | 16 | One-hot timing lines |
| seq_count | output | 4 | Step counter value |
| pc | output | 12 | Program counter |
| ar | output | 12 | Address register |
| ir | output | 16 | Instruction register |
| tr | output | 16 | Temporary register |
| ind_bit | output | 1 | Captured indirect bit |
| int_pend | output | 1 | Interrupt pending flag |
| ien | output | 1 | Interrupt enable |

## Verification
Some properties are checked on every clock. These are the one-hot timing lines and the counter advance, the fetch update of IR and PC, and the pending-flag set condition. Also checked every clock: the write strobe is confined to INT_STORE, the INT_VECTOR exit state is reached, and nothing moves while run is low.

Other behaviour shows only in the bench's long mixed runs against its behavioural model. This covers indirect address resolution from real memory contents, and the return address being saved and later read back. It also covers branch and skip requests being ignored outside EXECUTE, the priority between enable requests, and counter wrap when no restart ever comes.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        PH_FETCH_ADDR,
        PH_FETCH_READ,
        PH_DECODE,
        PH_INDIRECT,
        PH_EXECUTE,
        PH_INT_SAVE,
        PH_INT_STORE,
        PH_INT_VECTOR
    } phase_e;

    typedef struct packed {
        logic ar_from_pc;
        logic fetch;
        logic decode;
        logic indirect;
        logic exec;
        logic int_save;
        logic int_store;
        logic int_vector;
    } ctl_t;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int SC_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 clr,
    output logic [SC_W-1:0]      count,
    output logic [(1<<SC_W)-1:0] tstep
);
    localparam int NT = 1 << SC_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (adv)
            count <= clr ? '0 : count + 1'b1;
    end

    for (genvar k = 0; k < NT; k++) begin : g_tdec
        assign tstep[k] = (count == SC_W'(k));
    end

    assert_tstep_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tstep) == 1);

    assert_sc_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> count == SC_W'($past(count) + 1'b1));

    assert_sc_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && clr) |=> tstep[0]);

endmodule

// File: rtl/op_decoder.sv
module op_decoder #(
    parameter int OP_W = 3
) (
    input  logic [OP_W-1:0]      op,
    output logic [(1<<OP_W)-1:0] lines
);
    localparam int NL = 1 << OP_W;

    for (genvar k = 0; k < NL; k++) begin : g_odec
        assign lines[k] = (op == OP_W'(k));
    end

endmodule

// File: rtl/phase_ctrl.sv
module phase_ctrl
    import seq_pkg::*;
#(
    parameter int SC_W = 4
) (
    input  logic [SC_W-1:0] seq_count,
    input  logic            int_pend,
    input  logic            op_is_top,
    input  logic            ind_bit,
    output phase_e          phase,
    output ctl_t            ctl
);
    localparam logic [SC_W-1:0] STEP0 = SC_W'(0);
    localparam logic [SC_W-1:0] STEP1 = SC_W'(1);
    localparam logic [SC_W-1:0] STEP2 = SC_W'(2);
    localparam logic [SC_W-1:0] STEP3 = SC_W'(3);

    // Phase selection from counter and flags
    always_comb begin
        if (int_pend && seq_count == STEP0)      phase = PH_INT_SAVE;
        else if (int_pend && seq_count == STEP1) phase = PH_INT_STORE;
        else if (int_pend && seq_count == STEP2) phase = PH_INT_VECTOR;
        else if (seq_count == STEP0)             phase = PH_FETCH_ADDR;
        else if (seq_count == STEP1)             phase = PH_FETCH_READ;
        else if (seq_count == STEP2)             phase = PH_DECODE;
        else if (seq_count == STEP3 && !int_pend && !op_is_top && ind_bit)
                                                 phase = PH_INDIRECT;
        else                                     phase = PH_EXECUTE;
    end

    // Control strobes per phase
    always_comb begin
        ctl = '0;
        unique case (phase)
            PH_FETCH_ADDR: ctl.ar_from_pc = 1'b1;
            PH_FETCH_READ: ctl.fetch      = 1'b1;
            PH_DECODE:     ctl.decode     = 1'b1;
            PH_INDIRECT:   ctl.indirect   = 1'b1;
            PH_EXECUTE:    ctl.exec       = 1'b1;
            PH_INT_SAVE:   ctl.int_save   = 1'b1;
            PH_INT_STORE:  ctl.int_store  = 1'b1;
            PH_INT_VECTOR: ctl.int_vector = 1'b1;
        endcase
    end

endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
    import seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int SC_W   = 4,
    parameter int OP_W   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  in_flag,
    input  logic                  out_flag,
    input  logic                  sc_clear,
    input  logic                  pc_inc_req,
    input  logic                  pc_load_req,
    input  logic [ADDR_W-1:0]     pc_load_addr,
    input  logic                  ien_on,
    input  logic                  ien_off,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic                  mem_we,
    output logic [(1<<OP_W)-1:0]  op_lines,
    output logic [(1<<SC_W)-1:0]  tstep,
    output logic [SC_W-1:0]       seq_count,
    output logic [ADDR_W-1:0]     pc,
    output logic [ADDR_W-1:0]     ar,
    output logic [DATA_W-1:0]     ir,
    output logic [DATA_W-1:0]     tr,
    output logic                  ind_bit,
    output logic                  int_pend,
    output logic                  ien
);
    localparam int OP_LSB = ADDR_W;
    localparam int IND_POS = DATA_W - 1;
    localparam int PAD_W = DATA_W - ADDR_W;
    localparam logic [SC_W-1:0] FIRST_EXEC_STEP = SC_W'(3);

    phase_e phase;
    ctl_t   ctl;
    logic [OP_W-1:0] opcode;
    logic            op_is_top;
    logic            sc_clr;
    logic            irq_req;

    assign opcode    = ir[OP_LSB +: OP_W];
    assign op_is_top = &opcode;

    op_decoder #(.OP_W(OP_W)) u_opdec (
        .op    (opcode),
        .lines (op_lines)
    );

    phase_ctrl #(.SC_W(SC_W)) u_phase (
        .seq_count (seq_count),
        .int_pend  (int_pend),
        .op_is_top (op_is_top),
        .ind_bit   (ind_bit),
        .phase     (phase),
        .ctl       (ctl)
    );

    assign sc_clr = ctl.int_vector | (ctl.exec & sc_clear);

    seq_timer #(.SC_W(SC_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (run),
        .clr   (sc_clr),
        .count (seq_count),
        .tstep (tstep)
    );

    assign irq_req   = !int_pend && (seq_count >= FIRST_EXEC_STEP) && ien && (in_flag || out_flag);
    assign mem_addr  = ar;
    assign mem_wdata = tr;
    assign mem_we    = run & ctl.int_store;

    // Register state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc       <= '0;
            ar       <= '0;
            ir       <= '0;
            tr       <= '0;
            ind_bit  <= 1'b0;
            int_pend <= 1'b0;
            ien      <= 1'b0;
        end else if (run) begin
            if (ctl.ar_from_pc)
                ar <= pc;
            if (ctl.fetch) begin
                ir <= mem_rdata;
                pc <= pc + 1'b1;
            end
            if (ctl.decode) begin
                ar      <= ir[ADDR_W-1:0];
                ind_bit <= ir[IND_POS];
            end
            if (ctl.indirect)
                ar <= mem_rdata[ADDR_W-1:0];
            if (ctl.int_save) begin
                ar <= '0;
                tr <= {{PAD_W{1'b0}}, pc};
            end
            if (ctl.int_store)
                pc <= '0;
            if (ctl.int_vector)
                pc <= pc + 1'b1;
            if (ctl.exec) begin
                if (pc_load_req)
                    pc <= pc_load_addr;
                else if (pc_inc_req)
                    pc <= pc + 1'b1;
            end

            if (ctl.int_vector || ien_off)
                ien <= 1'b0;
            else if (ien_on)
                ien <= 1'b1;

            if (ctl.int_vector)
                int_pend <= 1'b0;
            else if (irq_req)
                int_pend <= 1'b1;
        end
    end

    assert_fetch_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !int_pend && tstep[1]) |=>
            (ir == $past(mem_rdata) && pc == ADDR_W'($past(pc) + 1'b1)));

    assert_irq_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !int_pend && ien && (in_flag || out_flag) && !tstep[0] && !tstep[1] && !tstep[2])
            |=> int_pend);

    assert_write_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int_pend && tstep[1] && run));

    assert_vector_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && int_pend && tstep[2]) |=>
            (tstep[0] && !int_pend && !ien && pc == ADDR_W'(1)));

    assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(seq_count) && $stable(pc) && $stable(ar) && $stable(ir)
                  && $stable(tr) && $stable(ien) && $stable(int_pend)));

endmodule

// File: tb/instr_cycle_seq_tb.sv
module instr_cycle_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_CYCLES   = 6000;

    logic clk = 1'b0;
    logic rst_n, run, in_flag, out_flag, sc_clear, pc_inc_req, pc_load_req, ien_on, ien_off;
    logic [11:0] pc_load_addr;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr, pc, ar;
    logic [15:0] mem_wdata, ir, tr, tstep;
    logic        mem_we, ind_bit, int_pend, ien;
    logic [7:0]  op_lines;
    logic [3:0]  seq_count;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    instr_cycle_seq dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .in_flag(in_flag), .out_flag(out_flag),
        .sc_clear(sc_clear), .pc_inc_req(pc_inc_req), .pc_load_req(pc_load_req),
        .pc_load_addr(pc_load_addr), .ien_on(ien_on), .ien_off(ien_off),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .op_lines(op_lines), .tstep(tstep), .seq_count(seq_count), .pc(pc), .ar(ar),
        .ir(ir), .tr(tr), .ind_bit(ind_bit), .int_pend(int_pend), .ien(ien)
    );

    // Memory: computed contents, overlaid by writes
    logic [15:0] wmem [int];

    function automatic logic [15:0] mem_rd(input logic [11:0] a);
        int ai = int'(a);
        if (wmem.exists(ai)) return wmem[ai];
        return 16'((ai * 40503 + 12345) ^ (ai << 7));
    endfunction

    // Behavioural reference model
    logic [3:0]  m_sc;
    logic [11:0] m_pc, m_ar;
    logic [15:0] m_ir, m_tr;
    logic        m_i, m_r, m_ien;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sc = 0; m_pc = 0; m_ar = 0; m_ir = 0; m_tr = 0; m_i = 0; m_r = 0; m_ien = 0;
        end else if (run) begin
            logic [3:0]  n_sc;
            logic [11:0] n_pc, n_ar;
            logic [15:0] n_ir, n_tr, rd;
            logic        n_i, n_r, n_ien, indir, in_exec, in_int;
            rd = mem_rd(m_ar);
            n_sc = m_sc + 4'd1; n_pc = m_pc; n_ar = m_ar; n_ir = m_ir; n_tr = m_tr;
            n_i = m_i; n_r = m_r; n_ien = m_ien;
            in_int  = m_r && (m_sc < 3);
            indir   = !m_r && m_sc == 3 && m_ir[14:12] != 3'd7 && m_i;
            in_exec = (m_sc >= 3) && !indir;
            if (in_int) begin
                case (m_sc)
                    0: begin n_ar = 0; n_tr = {4'd0, m_pc}; end
                    1: begin wmem[int'(m_ar)] = m_tr; n_pc = 0; end
                    default: begin n_pc = m_pc + 12'd1; n_r = 0; n_sc = 0; end
                endcase
            end else if (m_sc == 0) n_ar = m_pc;
            else if (m_sc == 1) begin n_ir = rd; n_pc = m_pc + 12'd1; end
            else if (m_sc == 2) begin n_ar = m_ir[11:0]; n_i = m_ir[15]; end
            else if (indir) n_ar = rd[11:0];
            if (in_exec) begin
                if (pc_load_req) n_pc = pc_load_addr;
                else if (pc_inc_req) n_pc = m_pc + 12'd1;
                if (sc_clear) n_sc = 0;
            end
            if (ien_off) n_ien = 0;
            else if (ien_on) n_ien = 1;
            if (in_int && m_sc == 2) n_ien = 0;
            if (!m_r && m_sc >= 3 && m_ien && (in_flag || out_flag)) n_r = 1;
            m_sc = n_sc; m_pc = n_pc; m_ar = n_ar; m_ir = n_ir; m_tr = n_tr;
            m_i = n_i; m_r = n_r; m_ien = n_ien;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input bit in_reset);
        chk(in_reset ? "R1" : "R2", "seq_count", 32'(seq_count), 32'(m_sc));
        chk(in_reset ? "R1" : "R2", "tstep", 32'(tstep), 32'(16'd1 << m_sc));
        chk(in_reset ? "R1" : "R3/R8", "pc", 32'(pc), 32'(m_pc));
        chk(in_reset ? "R1" : "R5/R7", "ar", 32'(ar), 32'(m_ar));
        chk(in_reset ? "R1" : "R5", "mem_addr", 32'(mem_addr), 32'(m_ar));
        chk(in_reset ? "R1" : "R3", "ir", 32'(ir), 32'(m_ir));
        chk(in_reset ? "R1" : "R7", "tr", 32'(tr), 32'(m_tr));
        chk(in_reset ? "R1" : "R4", "ind_bit", 32'(ind_bit), 32'(m_i));
        chk(in_reset ? "R1" : "R4", "op_lines", 32'(op_lines), 32'(8'd1 << m_ir[14:12]));
        chk(in_reset ? "R1" : "R6", "int_pend", 32'(int_pend), 32'(m_r));
        chk(in_reset ? "R1" : "R9", "ien", 32'(ien), 32'(m_ien));
        chk("R7", "mem_we", 32'(mem_we), 32'(run && rst_n && m_r && m_sc == 0 + 1));
        if (mem_we) chk("R7", "mem_wdata", 32'(mem_wdata), 32'(m_tr));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        logic [3:0] prev_sc;
        logic       prev_run;
        rst_n = 0; run = 0; in_flag = 0; out_flag = 0; sc_clear = 0; pc_inc_req = 0;
        pc_load_req = 0; pc_load_addr = 0; ien_on = 0; ien_off = 0; mem_rdata = 0;
        prev_sc = 0; prev_run = 1;
        for (int cyc = 0; cyc < N_CYCLES; cyc++) begin
            bit wrap_seg;
            @(negedge clk);
            compare_all(cyc <= 3);
            // R10: counter frozen across a halted cycle
            if (cyc > 4 && !prev_run)
                chk("R10", "halt seq_count", 32'(seq_count), 32'(prev_sc));
            prev_sc = seq_count;
            wrap_seg = (cyc >= 2500 && cyc < 3200);
            if (cyc == 3) rst_n = 1;
            if (cyc >= 3) begin
                run          = (cyc < 20) ? 1'b1 : ($urandom % 10 != 0);
                in_flag      = ($urandom % 10 == 0);
                out_flag     = ($urandom % 12 == 0);
                sc_clear     = wrap_seg ? 1'b0 : ($urandom % 3 == 0);
                pc_inc_req   = ($urandom % 5 == 0);
                pc_load_req  = ($urandom % 7 == 0);
                pc_load_addr = 12'($urandom);
                ien_on       = ($urandom % 12 == 0);
                ien_off      = ($urandom % 40 == 0);
            end
            prev_run = run;
            mem_rdata = mem_rd(mem_addr);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule